// File: doc/BRIEF.md
# Transmit DMA Channel Control and Error Tracker

This block holds the software-visible control and status for a bank of transmit DMA channels. Each channel has a configuration word that selects its run mode and enables its internal request path. A shared status word shows, per channel, whether its buffers have drained and whether it has no request outstanding. A shared error word collects sticky fault flags, some global and some per channel, and software clears each one by writing 1 to it. The engine that moves the data is outside this block. It feeds in per-channel events and reads back the per-channel idle indication.

Software reaches the registers through a plain register port. The port has a write strobe, an address and write data, and a read data bus that is decoded combinationally from the address. Channel `c` has its configuration word at byte offset `0x20*c`. The status word sits at `0x100` and the error word at `0x104`. Every event and status pin is a plain level or a one-cycle pulse. No stream handshake is involved.

Top module: `txdma_status_tracker`

## Requirements
- R1: After reset every configuration word reads 0, the error word reads 0, and the status word reads `0x00FF0000`, which means no buffers reported empty and no requests pending.
- R2: A write to offset `0x20*c` stores bits 31:30 (mode: 00 off, 01 stop at end of frame, 10 run, 11 treated as off) and bit 3 (request enable) for channel `c`. A read of that offset returns those bits, and every other bit reads 0.
- R3: Status bit `24+c` is 1 exactly when `buf_empty[c]` was high at the previous clock edge.
- R4: Status bit `16+c` is 0, meaning a request is pending, one cycle after `chan_req[c]` is high while channel `c` is in run mode with request enable set. In off mode, or with request enable clear, the bit stays 1 whatever `chan_req[c]` does.
- R5: In stop-at-end-of-frame mode a channel keeps reporting its pending request until a `frame_end[c]` pulse. From the cycle after the pulse it reports no pending request even if `chan_req[c]` stays high, and this lasts until the mode is changed.
- R6: `chan_idle[c]` is high only when channel `c` is not in run mode, its buffer-empty status bit is 1 and its no-pending status bit is 1.
- R7: Error bit 31 is set one cycle after an `addr_fault` pulse. Error bit 30 is set one cycle after a `short_xfer` pulse.
- R8: Error bit `9+c` is set one cycle after `cmd_start[c]` and `cmd_full[c]` are high together. A start with the command buffer not full sets nothing.
- R9: Error bit `c` is set one cycle after `fifo_full[c]` is high while channel `c`'s 8-bit credit count (`credit[8*c+7:8*c]`) is nonzero. A full indication with a zero credit count sets nothing.
- R10: Error flags are sticky. Writing 1 to an error bit at `0x104` clears it, and writing 0 leaves it. If an event sets a bit in the same cycle that software clears it, the bit ends up set.
- R11: `err_any` is high exactly when the error word is nonzero.
- R12: Writes to the status word have no effect. Error bits 29:17 and bit 8 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| buf_empty | input | 8 | Per-channel buffers empty |
| chan_req | input | 8 | Per-channel request raised by the engine |
| frame_end | input | 8 | Per-channel end-of-frame pulse |
| cmd_start | input | 8 | Per-channel start command pulse |
| cmd_full | input | 8 | Per-channel command buffer still full |
| fifo_full | input | 8 | Per-channel FIFO full indication |
| credit | input | 64 | Per-channel credit count, 8 bits each |
| addr_fault | input | 1 | Bad internal address pulse |
| short_xfer | input | 1 | Host sent too few dwords pulse |
| chan_idle | output | 8 | Per-channel idle |
| err_any | output | 1 | Any error flag set |

## Verification
The properties assume the event inputs are synchronous and hold steady across each clock edge. They also assume a register write targets one decoded address per cycle. The bench drives every input on the falling edge and raises the strobe for exactly one cycle per access. The sticky-flag property assumes no set event lands on a bit during the cycle the bit is checked. The stimulus keeps error events and error-word writes in separate cycles, except in the one directed case that tests set-over-clear.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_STOP = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSVD = 2'b11
  } txdma_mode_e;

  localparam int ADDR_W      = 12;
  localparam int DATA_W      = 32;
  localparam int CFG_SHIFT   = 5;          // 0x20 stride between channel words
  localparam logic [ADDR_W-1:0] STAT_OFS = 12'h100;
  localparam logic [ADDR_W-1:0] ERR_OFS  = 12'h104;

  localparam int ST_EMPTY_LSB = 24;
  localparam int ST_NOPEND_LSB = 16;
  localparam int ER_ADDR_BIT  = 31;
  localparam int ER_SHORT_BIT = 30;
  localparam int ER_OVR_LSB   = 9;
  localparam int ER_CRED_LSB  = 0;
endpackage

// File: rtl/txdma_chan_ctl.sv
module txdma_chan_ctl
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_mode_in,
  input  logic       cfg_en_in,
  input  logic       buf_empty,
  input  logic       req,
  input  logic       frame_end,
  output logic [1:0] mode_o,
  output logic       en_o,
  output logic       empty_q,
  output logic       pend_q,
  output logic       idle
);
  txdma_mode_e mode_q;
  logic        stop_q, stop_d, may_req;

  // A frame-end seen in stop mode latches the channel stopped until the mode moves.
  assign stop_d  = (mode_q == MODE_STOP) && (stop_q || frame_end);
  assign may_req = en_o && ((mode_q == MODE_RUN) || ((mode_q == MODE_STOP) && !stop_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_OFF;
      en_o    <= 1'b0;
      stop_q  <= 1'b0;
      pend_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        mode_q <= txdma_mode_e'(cfg_mode_in);
        en_o   <= cfg_en_in;
      end
      stop_q  <= stop_d;
      pend_q  <= req && may_req;
      empty_q <= buf_empty;
    end
  end

  assign mode_o = mode_q;
  assign idle   = (mode_q != MODE_RUN) && empty_q && !pend_q;
endmodule

// File: rtl/txdma_err_log.sv
module txdma_err_log
  import txdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [NCH-1:0]    cmd_start,
  input  logic [NCH-1:0]    cmd_full,
  input  logic [NCH-1:0]    fifo_full,
  input  logic [NCH*CW-1:0] credit,
  input  logic              addr_fault,
  input  logic              short_xfer,
  output logic [DATA_W-1:0] err_q
);
  logic [NCH-1:0]    cred_nz;
  logic [DATA_W-1:0] set_vec, clr_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_nz
    assign cred_nz[c] = |credit[c*CW +: CW];
  end

  always_comb begin
    set_vec = '0;
    set_vec[ER_ADDR_BIT]  = addr_fault;
    set_vec[ER_SHORT_BIT] = short_xfer;
    set_vec[ER_OVR_LSB  +: NCH] = cmd_start & cmd_full;
    set_vec[ER_CRED_LSB +: NCH] = fifo_full & cred_nz;
    clr_vec = clr_we ? clr_mask : '0;
  end

  // Set has priority over a same-cycle write-one clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (err_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/txdma_status_tracker.sv
module txdma_status_tracker
  import txdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    buf_empty,
  input  logic [NCH-1:0]    chan_req,
  input  logic [NCH-1:0]    frame_end,
  input  logic [NCH-1:0]    cmd_start,
  input  logic [NCH-1:0]    cmd_full,
  input  logic [NCH-1:0]    fifo_full,
  input  logic [NCH*CW-1:0] credit,
  input  logic              addr_fault,
  input  logic              short_xfer,
  output logic [NCH-1:0]    chan_idle,
  output logic              err_any
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  if (NCH > 8) begin : g_bad_nch
    $error("NCH must not exceed 8");
  end

  logic [ADDR_W-CFG_SHIFT-1:0] slot;
  logic                        cfg_hit;
  logic [IDX_W-1:0]            cfg_idx;
  logic [NCH-1:0]              cfg_we, empty_q, pend_q, en_q;
  logic [1:0]                  mode_q [NCH];
  logic [DATA_W-1:0]           stat_word, err_vec;

  assign slot    = reg_addr[ADDR_W-1:CFG_SHIFT];
  assign cfg_hit = (int'(slot) < NCH) && (reg_addr[CFG_SHIFT-1:0] == '0);
  assign cfg_idx = slot[IDX_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign cfg_we[c] = reg_wr && cfg_hit && (cfg_idx == IDX_W'(c));
    txdma_chan_ctl u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we[c]),
      .cfg_mode_in(reg_wdata[31:30]),
      .cfg_en_in  (reg_wdata[3]),
      .buf_empty  (buf_empty[c]),
      .req        (chan_req[c]),
      .frame_end  (frame_end[c]),
      .mode_o     (mode_q[c]),
      .en_o       (en_q[c]),
      .empty_q    (empty_q[c]),
      .pend_q     (pend_q[c]),
      .idle       (chan_idle[c])
    );
  end

  txdma_err_log #(.NCH(NCH), .CW(CW)) u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_we    (reg_wr && (reg_addr == ERR_OFS)),
    .clr_mask  (reg_wdata),
    .cmd_start (cmd_start),
    .cmd_full  (cmd_full),
    .fifo_full (fifo_full),
    .credit    (credit),
    .addr_fault(addr_fault),
    .short_xfer(short_xfer),
    .err_q     (err_vec)
  );

  always_comb begin
    stat_word = '0;
    stat_word[ST_EMPTY_LSB  +: NCH] = empty_q;
    stat_word[ST_NOPEND_LSB +: NCH] = ~pend_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (cfg_hit) begin
      reg_rdata[31:30] = mode_q[cfg_idx];
      reg_rdata[3]     = en_q[cfg_idx];
    end else if (reg_addr == STAT_OFS) begin
      reg_rdata = stat_word;
    end else if (reg_addr == ERR_OFS) begin
      reg_rdata = err_vec;
    end
  end

  assign err_any = |err_vec;
endmodule

// File: rtl/txdma_status_tracker_chk.sv
module txdma_status_tracker_chk
  import txdma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [11:0]       reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NCH-1:0]    cmd_start,
  input logic [NCH-1:0]    cmd_full,
  input logic [NCH-1:0]    fifo_full,
  input logic [NCH*CW-1:0] credit,
  input logic              addr_fault,
  input logic [31:0]       err_vec,
  input logic [31:0]       stat_word,
  input logic [NCH-1:0]    chan_idle
);
  logic [NCH-1:0] nz;
  logic           err_wr;
  for (genvar c = 0; c < NCH; c++) begin : g_nz
    assign nz[c] = credit[c*CW +: CW] != '0;
  end
  assign err_wr = reg_wr && (reg_addr == ERR_OFS);

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cmd_start & cmd_full)) |=>
      ((err_vec[ER_OVR_LSB +: NCH] & $past(cmd_start & cmd_full)) == $past(cmd_start & cmd_full)));

  p_credit_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fifo_full & nz)) |=>
      ((err_vec[ER_CRED_LSB +: NCH] & $past(fifo_full & nz)) == $past(fifo_full & nz)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !err_wr |=> ((err_vec & $past(err_vec)) == $past(err_vec)));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wr && reg_wdata[ER_ADDR_BIT] && !addr_fault) |=> !err_vec[ER_ADDR_BIT]);

  p_reserved_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vec[29:17] == '0) && !err_vec[8]);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_idle & ~stat_word[ST_EMPTY_LSB +: NCH]) == '0) &&
    ((chan_idle & ~stat_word[ST_NOPEND_LSB +: NCH]) == '0));
endmodule

bind txdma_status_tracker txdma_status_tracker_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cmd_start (cmd_start),
  .cmd_full  (cmd_full),
  .fifo_full (fifo_full),
  .credit    (credit),
  .addr_fault(addr_fault),
  .err_vec   (err_vec),
  .stat_word (stat_word),
  .chan_idle (chan_idle)
);

// File: tb/txdma_status_tracker_test.sv
module txdma_status_tracker_test;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [7:0]  buf_empty = 0, chan_req = 0, frame_end = 0, cmd_start = 0, cmd_full = 0, fifo_full = 0;
  logic [63:0] credit = 0;
  logic        addr_fault = 0, short_xfer = 0;
  logic [7:0]  chan_idle;
  logic        err_any;
  int n_run = 0, n_fail = 0;

  localparam logic [11:0] ST = 12'h100, ER = 12'h104;

  always #5 clk = ~clk;

  txdma_status_tracker uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h060, d); chk("R1 cfg", d, 0);
    rd(ER, d);      chk("R1 err", d, 0);
    rd(ST, d);      chk("R1 status", d, 32'h00FF0000);
    chk("R11 reset", {31'b0, err_any}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(12'h0A0, 32'hBFFF_FFFF);
    rd(12'h0A0, d); chk("R2 ch5 masked", d, 32'h8000_0008);
    rd(12'h080, d); chk("R2 ch4 untouched", d, 0);
    wr(12'h0A0, 32'h0);
  endtask

  task automatic t_empty();
    logic [31:0] d;
    buf_empty = 8'h81; tick();
    rd(ST, d); chk("R3 empty", d, 32'h81FF0000);
    buf_empty = 8'h00; tick();
    rd(ST, d); chk("R3 empty drop", d, 32'h00FF0000);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    chan_req = 8'h07;
    wr(12'h000, 32'h8000_0008);  // ch0 run+en
    wr(12'h020, 32'h8000_0000);  // ch1 run, en clear
    tick();                       // ch2 off
    rd(ST, d); chk("R4 pending", d, 32'h00FE0000);
    chan_req = 0; tick();
    rd(ST, d); chk("R4 released", d, 32'h00FF0000);
    wr(12'h000, 0); wr(12'h020, 0);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    chan_req = 8'h08; buf_empty = 8'h08;
    wr(12'h060, 32'h8000_0008); tick();
    rd(ST, d); chk("R4 ch3 run", d[19], 0);
    chk("R6 run not idle", {31'b0, chan_idle[3]}, 0);
    wr(12'h060, 32'h4000_0008); tick();
    rd(ST, d); chk("R5 still pending", d[19], 0);
    chk("R6 pending not idle", {31'b0, chan_idle[3]}, 0);
    frame_end = 8'h08; tick(); frame_end = 0;
    rd(ST, d); chk("R5 dropped at eof", d[19], 1);
    tick();
    rd(ST, d); chk("R5 held after eof", d[19], 1);
    chk("R6 idle", {31'b0, chan_idle[3]}, 1);
    wr(12'h060, 32'h8000_0008); tick();
    rd(ST, d); chk("R5 resumes on mode change", d[19], 0);
    chan_req = 0; buf_empty = 0; wr(12'h060, 0); tick();
  endtask

  task automatic t_err_global();
    logic [31:0] d;
    addr_fault = 1; tick(); addr_fault = 0;
    rd(ER, d); chk("R7 addr", d, 32'h8000_0000);
    chk("R11 any", {31'b0, err_any}, 1);
    short_xfer = 1; tick(); short_xfer = 0;
    rd(ER, d); chk("R7 short", d, 32'hC000_0000);
    wr(ER, 32'h4000_0000);
    rd(ER, d); chk("R10 clear one", d, 32'h8000_0000);
    wr(ER, 32'h8000_0000);
    rd(ER, d); chk("R10 clear all", d, 0);
    chk("R11 none", {31'b0, err_any}, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    cmd_start = 8'h24; cmd_full = 8'h21; tick(); cmd_start = 0; cmd_full = 0;
    rd(ER, d); chk("R8 overrun ch5", d, 32'h0000_4000);
    wr(ER, 32'hFFFF_FFFF);
  endtask

  task automatic t_credit();
    logic [31:0] d;
    fifo_full = 8'h06; credit = 0; credit[15:8] = 8'h01;
    tick(); fifo_full = 0; credit = 0;
    rd(ER, d); chk("R9 credit ch1 only", d, 32'h0000_0002);
    wr(ER, 32'h0000_0002);
    rd(ER, d); chk("R10 credit cleared", d, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    addr_fault = 1; wr(ER, 32'h8000_0000); addr_fault = 0;
    rd(ER, d); chk("R10 set wins", d, 32'h8000_0000);
    wr(ER, 32'h0000_0000);
    rd(ER, d); chk("R10 zero write keeps", d, 32'h8000_0000);
    wr(ER, 32'hFFFF_FFFF);
  endtask

  task automatic t_ro();
    logic [31:0] d;
    wr(ST, 32'hFFFF_FFFF);
    rd(ST, d); chk("R12 status ro", d, 32'h00FF0000);
    wr(ER, 32'hFFFF_FFFF);
    rd(ER, d); chk("R12 reserved zero", d, 0);
  endtask

  initial begin
    fork
      begin
        #3; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
        t_reset(); t_cfg(); t_empty(); t_pend(); t_stop();
        t_err_global(); t_overrun(); t_credit(); t_setwins(); t_ro();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule